// File: doc/BRIEF.md
# Gated Clock Fanout Divider

This block takes two candidate input clocks, picks one with a select input, and fans the chosen clock out to two banks of true/complement output pairs. The full-rate bank repeats the chosen clock cycle for cycle. The half-rate bank carries that clock divided by two. Within a bank, every pair carries the same waveform.

An enable input may change at any moment with no relation to either clock. It is captured by a level-sensitive stage that is open only while the selected clock is low. Starting or stopping therefore happens at clean cycle boundaries, and no output sees a shortened pulse. The half-rate bank has a second gating stage that is open only while the divided phase is low, so its long pulses are never cut. A master reset clears the divider at once and holds every true output low.

Top module: `gated_fanout_div`

## Requirements
- R1: When `useAltSrc` is 1, the outputs are derived from `srcClkB`. When it is 0, they are derived from `srcClkA`.
- R2: When the enable is low, every true output goes low and every complement output goes high.
- R3: A change on `clkEnable` has no visible effect during the current high phase of the selected clock. A change made while the clock is high shows on the full-rate bank from the next rising edge.
- R4: Full-rate outputs follow the selected clock. Half-rate outputs toggle on every rising edge of the selected clock, so they run at half its frequency.
- R5: While `masterReset` is high, all true outputs are low and the divider is cleared. Assertion of the reset acts at once, without waiting for a clock edge.
- R6: Each complement output is always the inverse of its paired true output.
- R7: All pairs within one bank carry identical waveforms.
- R8: After reset is released with the enable high, the first rising edge of the selected clock drives the half-rate bank high.
- R9: The divider keeps counting while the outputs are disabled. After re-enable, the half-rate phase matches the count of selected-clock rising edges since reset.
- R10: When the enable toggles at arbitrary times, no output high or low pulse is shorter than half a selected-clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClkA | input | 1 | First candidate clock |
| srcClkB | input | 1 | Second candidate clock |
| useAltSrc | input | 1 | 1 selects srcClkB, 0 selects srcClkA |
| clkEnable | input | 1 | Asynchronous output enable, active high |
| masterReset | input | 1 | Asynchronous reset, active high |
| fullRateOut | output | COPIES_A | Full-rate true outputs |
| fullRateOutN | output | COPIES_A | Full-rate complement outputs |
| halfRateOut | output | COPIES_B | Half-rate true outputs |
| halfRateOutN | output | COPIES_B | Half-rate complement outputs |

## Verification
A wrong divider state shows up within one selected-clock rising edge as a half-rate bank out of phase with the count of edges since reset. It can also appear as a half-rate output that stays high across two consecutive rising edges. A faulty enable stage can show up in three ways. The full-rate bank may react within the current high phase rather than at the next cycle. The outputs may stay active for a cycle after a disable. Or, under random enable toggling, a pulse narrower than half a clock period may appear. A reset path fault leaves a true output high within the same instant that reset rises.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;
  // strobes handed from the gating control to the clock datapath
  typedef struct packed {
    logic passFast;   // full-rate bank may pass the clock
    logic passSlow;   // half-rate bank may pass the divided clock
    logic clearDiv;   // hold the divider cleared
  } gateCtl_t;
endpackage

// File: rtl/clkfan_ctrl.sv
module clkfan_ctrl
  import clkfan_pkg::*;
(
  input  logic     fastClk,
  input  logic     slowPhase,
  input  logic     enableIn,
  input  logic     resetIn,
  output gateCtl_t ctl
);
  logic fastGate;
  logic slowGate;

  // open only while the selected clock is low: a change waits out a high phase
  always_latch begin
    if (resetIn)       fastGate <= 1'b0;
    else if (!fastClk) fastGate <= enableIn;
  end

  // second stage open only while the divided phase is low
  always_latch begin
    if (resetIn)         slowGate <= 1'b0;
    else if (!slowPhase) slowGate <= fastGate;
  end

  always_comb begin
    ctl.passFast = fastGate;
    ctl.passSlow = slowGate;
    ctl.clearDiv = resetIn;
  end
endmodule

// File: rtl/clkfan_path.sv
module clkfan_path
  import clkfan_pkg::*;
#(
  parameter int COPIES_A = 2,
  parameter int COPIES_B = 2
) (
  input  logic                srcA,
  input  logic                srcB,
  input  logic                pickB,
  input  gateCtl_t            ctl,
  output logic                fastClk,
  output logic                slowPhase,
  output logic [COPIES_A-1:0] fastOut,
  output logic [COPIES_A-1:0] fastOutN,
  output logic [COPIES_B-1:0] slowOut,
  output logic [COPIES_B-1:0] slowOutN
);
  logic clearNow;
  logic divQ;
  logic fastGated;
  logic slowGated;

  assign fastClk  = pickB ? srcB : srcA;
  assign clearNow = ctl.clearDiv;

  // divide by two, runs regardless of the enable so phase is kept
  always_ff @(posedge fastClk or posedge clearNow) begin
    if (clearNow) divQ <= 1'b0;
    else          divQ <= ~divQ;
  end

  assign slowPhase = divQ;
  assign fastGated = fastClk & ctl.passFast;
  assign slowGated = divQ & ctl.passSlow;

  for (genvar i = 0; i < COPIES_A; i++) begin : g_fast
    assign fastOut[i]  = fastGated;
    assign fastOutN[i] = ~fastGated;
  end

  for (genvar j = 0; j < COPIES_B; j++) begin : g_slow
    assign slowOut[j]  = slowGated;
    assign slowOutN[j] = ~slowGated;
  end
endmodule

// File: rtl/gated_fanout_div.sv
module gated_fanout_div
  import clkfan_pkg::*;
#(
  parameter int COPIES_A = 2,
  parameter int COPIES_B = 2
) (
  input  logic                srcClkA,
  input  logic                srcClkB,
  input  logic                useAltSrc,
  input  logic                clkEnable,
  input  logic                masterReset,
  output logic [COPIES_A-1:0] fullRateOut,
  output logic [COPIES_A-1:0] fullRateOutN,
  output logic [COPIES_B-1:0] halfRateOut,
  output logic [COPIES_B-1:0] halfRateOutN
);
  gateCtl_t gateCtl;
  logic     fastClk;
  logic     slowPhase;

  clkfan_ctrl u_ctrl (
    .fastClk  (fastClk),
    .slowPhase(slowPhase),
    .enableIn (clkEnable),
    .resetIn  (masterReset),
    .ctl      (gateCtl)
  );

  clkfan_path #(
    .COPIES_A(COPIES_A),
    .COPIES_B(COPIES_B)
  ) u_path (
    .srcA     (srcClkA),
    .srcB     (srcClkB),
    .pickB    (useAltSrc),
    .ctl      (gateCtl),
    .fastClk  (fastClk),
    .slowPhase(slowPhase),
    .fastOut  (fullRateOut),
    .fastOutN (fullRateOutN),
    .slowOut  (halfRateOut),
    .slowOutN (halfRateOutN)
  );
endmodule

// File: rtl/clkfan_chk.sv
module clkfan_chk #(
  parameter int COPIES_A = 2,
  parameter int COPIES_B = 2
) (
  input logic                srcClkA,
  input logic                srcClkB,
  input logic                useAltSrc,
  input logic                masterReset,
  input logic [COPIES_A-1:0] fullRateOut,
  input logic [COPIES_A-1:0] fullRateOutN,
  input logic [COPIES_B-1:0] halfRateOut,
  input logic [COPIES_B-1:0] halfRateOutN
);
  logic refClk;
  assign refClk = useAltSrc ? srcClkB : srcClkA;

  // R5
  reset_low_chk: assert property (@(posedge refClk)
    masterReset |-> (fullRateOut == '0 && halfRateOut == '0));

  // R6
  complement_chk: assert property (@(negedge refClk) disable iff (masterReset)
    (fullRateOutN == ~fullRateOut) && (halfRateOutN == ~halfRateOut));

  // R7
  copies_chk: assert property (@(negedge refClk) disable iff (masterReset)
    (fullRateOut == {COPIES_A{fullRateOut[0]}}) &&
    (halfRateOut == {COPIES_B{halfRateOut[0]}}));

  // R4
  half_rate_chk: assert property (@(posedge refClk) disable iff (masterReset)
    !($past(halfRateOut[0]) && halfRateOut[0]));
endmodule

bind gated_fanout_div clkfan_chk #(
  .COPIES_A(COPIES_A),
  .COPIES_B(COPIES_B)
) u_chk (
  .srcClkA     (srcClkA),
  .srcClkB     (srcClkB),
  .useAltSrc   (useAltSrc),
  .masterReset (masterReset),
  .fullRateOut (fullRateOut),
  .fullRateOutN(fullRateOutN),
  .halfRateOut (halfRateOut),
  .halfRateOutN(halfRateOutN)
);

// File: tb/gated_fanout_div_tb.sv
`timescale 1ns/1ps
module gated_fanout_div_tb;
  logic clkA = 1'b0;
  logic clkB = 1'b0;
  logic sel  = 1'b0;
  logic en   = 1'b1;
  logic rst  = 1'b1;
  logic [1:0] aOut, aOutN, bOut, bOutN;

  always #10 clkA = ~clkA;   // 50 MHz
  always #16 clkB = ~clkB;

  int checks = 0;
  int fails  = 0;
  logic parity;              // bench model of the divider for clkA

  always @(posedge clkA or posedge rst)
    if (rst) parity <= 1'b0;
    else     parity <= ~parity;

  gated_fanout_div u_dut (
    .srcClkA     (clkA),
    .srcClkB     (clkB),
    .useAltSrc   (sel),
    .clkEnable   (en),
    .masterReset (rst),
    .fullRateOut (aOut),
    .fullRateOutN(aOutN),
    .halfRateOut (bOut),
    .halfRateOutN(bOutN)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // checks a bank and its complement (R6) together
  task automatic chkA(string req, logic [1:0] exp);
    chk(req, "fullRate", {aOut, aOutN}, {exp, ~exp});
  endtask
  task automatic chkB(string req, logic [1:0] exp);
    chk(req, "halfRate", {bOut, bOutN}, {exp, ~exp});
  endtask

  task automatic midHigh(); @(posedge clkA); #5; endtask
  task automatic midLow();  @(negedge clkA); #5; endtask

  // pulse-width monitor for R10
  logic monOn = 1'b0;
  bit   seenA = 0, seenB = 0;
  realtime lastA, lastB;
  int runtA = 0, runtB = 0;
  always @(aOut[0]) if (monOn) begin
    if (seenA && ($realtime - lastA) < 9.999) runtA++;
    seenA = 1; lastA = $realtime;
  end
  always @(bOut[0]) if (monOn) begin
    if (seenB && ($realtime - lastB) < 9.999) runtB++;
    seenB = 1; lastB = $realtime;
  end

  task automatic testReset();
    repeat (3) begin
      midHigh();
      chkA("R5", 2'b00);
      chkB("R5", 2'b00);
    end
  endtask

  task automatic testRun();
    midLow();
    rst = 1'b0;
    for (int k = 0; k < 6; k++) begin
      midHigh();
      chkA("R4", 2'b11);
      chkB(k == 0 ? "R8" : "R4", {2{parity}});
      midLow();
      chkA("R4", 2'b00);
      chkB("R4", {2{parity}});
    end
  endtask

  task automatic testDisable();
    midHigh();
    en = 1'b0;
    #1 chkA("R3", 2'b11);      // current high phase untouched
    midLow();
    chkA("R2", 2'b00);
    midHigh();
    chkA("R2", 2'b00);
    repeat (2) midHigh();
    repeat (4) begin
      midHigh();
      chkA("R2", 2'b00);
      chkB("R2", 2'b00);
    end
  endtask

  task automatic testEnable();
    midHigh();
    en = 1'b1;
    #1 chkA("R3", 2'b00);      // no early start mid-phase
    midHigh();
    chkA("R3", 2'b11);
    repeat (2) midHigh();
    repeat (4) begin
      midHigh();
      chkB("R9", {2{parity}});
    end
  endtask

  task automatic testAsyncReset();
    midHigh();
    rst = 1'b1;
    #1 begin chkA("R5", 2'b00); chkB("R5", 2'b00); end
    repeat (2) begin
      midHigh();
      chkA("R5", 2'b00);
      chkB("R5", 2'b00);
    end
    midLow();
    rst = 1'b0;
    midHigh();
    chkB("R8", 2'b11);
  endtask

  task automatic testRunt();
    midLow();
    #0.5;
    monOn = 1'b1;
    repeat (200) begin
      #($urandom_range(3, 47));
      en = ~en;
    end
    en = 1'b1;
    repeat (4) midHigh();
    monOn = 1'b0;
    chk("R10", "fullRate short pulses", runtA, 0);
    chk("R10", "halfRate short pulses", runtB, 0);
  endtask

  task automatic testSelect();
    rst = 1'b1;
    #3 sel = 1'b1;
    @(negedge clkB); #5;
    rst = 1'b0;
    @(posedge clkB); #5;
    chkA("R1", 2'b11);
    chkB("R1", 2'b11);
    @(negedge clkB); #5;
    chkA("R1", 2'b00);
    @(posedge clkB); #5;
    chkA("R1", 2'b11);
    chkB("R1", 2'b00);
    repeat (8) begin
      #7 chkA("R1", {2{clkB}});
    end
  endtask

  bit finished = 0;

  initial begin
    testReset();
    testRun();
    testDisable();
    testEnable();
    testAsyncReset();
    testRunt();
    testSelect();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule